// File: doc/BRIEF.md
# Mode-Decoding Serial DAC Command Interface

This block is the serial slave front end of a bank of 32 DAC channels plus one offset channel. A host frames each command with an active-low frame select and shifts it in on a serial clock, MSB first. The first two bits of a frame choose one of four modes. An acquire-only frame asks a channel sequencer to sample the analog input. A write frame loads a 14-bit DAC code. A readback frame arms a register read. An acquire-and-read frame does an acquisition and also arms a read. Address frames are 10 bits long, and write frames are 24 bits long.

The block holds the 33 code registers itself. An armed read is delivered during the next frame: the selected code appears on the serial output, MSB first, and moves on one bit at each serial clock falling edge. The block times the quiet interval that must pass between frames. It also looks at the sequencers' busy lines. Any timing violation sets a sticky error flag, rejects the write, or returns an all-zero readback. All serial inputs are brought into the system clock domain through a small synchronizer.

Top module: `sdac_cmd_if`

## Requirements
- R1: After reset, the serial output, the error flag, the acquire requests and the write strobes are all low, and every code register reads back as 0.
- R2: A 24-bit frame whose mode bits are 01 writes the 14-bit code held in its last 14 bits into the channel given by the 8 address bits that follow the mode bits. It also gives a one-cycle write strobe for that channel on `dac_wr` and places the code on `dac_code`.
- R3: A 10-bit frame with mode 00 or 10 gives a one-cycle pulse on the addressed bit of `acq_req`. Address codes 0 to 31 select a channel, code 32 selects bit 32 (the offset channel), and code 63 selects every bit.
- R4: A write to address 63 loads every register, including the offset register. A write to address 32 loads only the offset register.
- R5: After a 10-bit frame with mode 11, the next frame drives the addressed 14-bit register on `dout`, MSB first, from the falling edge of frame select. The output moves to the next bit at each serial clock falling edge. Outside such a frame, `dout` is 0, and the input bits of the read frame are not decoded.
- R6: A 10-bit frame with mode 10 requests an acquisition and arms a read. If the channel's `acq_busy` is still high when the read frame starts, the read returns zeros and the error flag is set. Otherwise it returns the register value.
- R7: A frame is discarded with no write, no request and no error in two cases: it is not 24 bits with mode 01, or it is not 10 bits with another mode.
- R8: Address codes other than 0 to 32 and 63 are ignored in every mode. A read of address 63 is not armed.
- R9: A write frame that starts less than MIN_GAP clock cycles after the last serial clock falling edge of a preceding write frame is rejected and sets the error flag. A read frame that starts less than MIN_GAP cycles after the last serial clock falling edge of its address frame returns zeros and sets the error flag.
- R10: The error flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data in, MSB first |
| acq_busy | input | 33 | Busy level of each channel sequencer, bit 32 is the offset channel |
| dout | output | 1 | Serial readback data |
| acq_req | output | 33 | One-cycle acquisition request per channel |
| dac_wr | output | 33 | One-cycle write strobe per channel |
| dac_code | output | 14 | Code written with the strobe |
| err | output | 1 | Sticky timing-violation flag |

## Verification
A wrong bit count or a misplaced mode slice shows up at the end of the same frame. The result is a write or request that appears when it should not, or one that is missing. A corrupted code register is seen only through readback, so every write is checked by reading it back in the frame that follows the arming frame. A stale gap counter or a wrongly held busy check changes the first bit on `dout` and the level of `err` within a few clock cycles of the read frame's start.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int MODE_W    = 2;
  localparam int ADDR_W    = 8;
  localparam int CODE_W    = 14;
  localparam int SHORT_LEN = MODE_W + ADDR_W;
  localparam int LONG_LEN  = SHORT_LEN + CODE_W;

  typedef enum logic [MODE_W-1:0] {
    M_ACQ    = 2'b00,
    M_WRITE  = 2'b01,
    M_ACQ_RB = 2'b10,
    M_RB     = 2'b11
  } mode_e;

  localparam logic [ADDR_W-1:0] ADDR_OFS = 8'd32;
  localparam logic [ADDR_W-1:0] ADDR_ALL = 8'd63;

  // length a frame of the given mode must have
  function automatic logic len_matches(mode_e m, int unsigned n);
    return (m == M_WRITE) ? (n == LONG_LEN) : (n == SHORT_LEN);
  endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= RST_VAL;
    else        stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx #(
  parameter int SH_W    = 24,
  parameter int MIN_GAP = 40,
  localparam int CNT_W  = $clog2(SH_W + 2),
  localparam int GAP_W  = $clog2(MIN_GAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_lvl,
  input  logic             sclk_lvl,
  input  logic             sdin_lvl,
  output logic             fr_start,
  output logic             fr_end,
  output logic             bit_evt,
  output logic [SH_W-1:0]  shreg,
  output logic [CNT_W-1:0] bitcnt,
  output logic             gap_ok_now,
  output logic             gap_ok_start
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(MIN_GAP);

  logic             sync_q, sclk_q;
  logic [GAP_W-1:0] gap_cnt;

  assign fr_start   = sync_q & ~sync_lvl;
  assign fr_end     = ~sync_q & sync_lvl;
  assign bit_evt    = sclk_q & ~sclk_lvl & ~sync_lvl;
  assign gap_ok_now = (gap_cnt >= GAP_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      sync_q <= sync_lvl;
      sclk_q <= sclk_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
    end else if (fr_start) begin
      shreg  <= '0;
      bitcnt <= '0;
    end else if (bit_evt) begin
      shreg  <= {shreg[SH_W-2:0], sdin_lvl};
      if (bitcnt != CNT_MAX) bitcnt <= bitcnt + 1'b1;
    end
  end

  // cycles since the last serial clock fall, saturating at the limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_cnt <= GAP_LIM;
    else if (bit_evt)          gap_cnt <= '0;
    else if (gap_cnt < GAP_LIM) gap_cnt <= gap_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap_ok_start <= 1'b1;
    else if (fr_start) gap_ok_start <= gap_ok_now;
  end

  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bitcnt == CNT_MAX && !fr_start) |=> (bitcnt == CNT_MAX));

  // R9
  gap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_start && !gap_ok_now) |=> !gap_ok_start);
endmodule

// File: rtl/sdac_readback.sv
module sdac_readback #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          shift,
  input  logic          stop,
  output logic          dout
);
  logic [CW-1:0] out_sh;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sh <= '0;
      active <= 1'b0;
    end else if (load) begin
      out_sh <= load_val;
      active <= 1'b1;
    end else if (stop) begin
      out_sh <= '0;
      active <= 1'b0;
    end else if (shift && active) begin
      out_sh <= {out_sh[CW-2:0], 1'b0};
    end
  end

  assign dout = active & out_sh[CW-1];
endmodule

// File: rtl/sdac_cmd_if.sv
module sdac_cmd_if
  import sdac_pkg::*;
#(
  parameter int NCH     = 32,
  parameter int MIN_GAP = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic [NCH:0]      acq_busy,
  output logic              dout,
  output logic [NCH:0]      acq_req,
  output logic [NCH:0]      dac_wr,
  output logic [CODE_W-1:0] dac_code,
  output logic              err
);
  localparam int SH_W  = LONG_LEN;
  localparam int CNT_W = $clog2(SH_W + 2);
  localparam int IDX_W = $clog2(NCH + 1);

  // channel mask selected by an address code; zero for unused codes
  function automatic logic [NCH:0] addr_mask(logic [ADDR_W-1:0] a);
    logic [NCH:0] m;
    m = '0;
    if (int'(a) < NCH)     m[a[IDX_W-1:0]] = 1'b1;
    else if (a == ADDR_OFS) m[NCH] = 1'b1;
    else if (a == ADDR_ALL) m = '1;
    return m;
  endfunction

  function automatic logic [IDX_W-1:0] addr_idx(logic [ADDR_W-1:0] a);
    return (int'(a) < NCH) ? a[IDX_W-1:0] : IDX_W'(NCH);
  endfunction

  logic [2:0]       sync_out;
  logic             sync_lvl, sclk_lvl, sdin_lvl;
  logic             fr_start, fr_end, bit_evt, gap_ok_now, gap_ok_start;
  logic [SH_W-1:0]  shreg;
  logic [CNT_W-1:0] bitcnt;

  sdac_sync #(.W(3), .STAGES(2), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sync_n, sclk, sdin}), .dout(sync_out)
  );
  assign {sync_lvl, sclk_lvl, sdin_lvl} = sync_out;

  sdac_frame_rx #(.SH_W(SH_W), .MIN_GAP(MIN_GAP)) u_rx (
    .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl), .sclk_lvl(sclk_lvl),
    .sdin_lvl(sdin_lvl), .fr_start(fr_start), .fr_end(fr_end),
    .bit_evt(bit_evt), .shreg(shreg), .bitcnt(bitcnt),
    .gap_ok_now(gap_ok_now), .gap_ok_start(gap_ok_start)
  );

  // state
  logic [CODE_W-1:0] bank [NCH+1];
  logic              in_rb, rb_arm, rb_acq, prev_dac;
  logic [IDX_W-1:0]  rb_idx;

  // decode at the end of a command frame
  logic              is_long, cmd_end, len_ok;
  mode_e             mode_s;
  logic [ADDR_W-1:0] addr_s;
  logic [CODE_W-1:0] code_s;
  logic [NCH:0]      mask_s;
  logic              wr_try, wr_go, wr_bad, acq_go, arm_go;
  logic              rb_start, rb_viol;
  logic [CODE_W-1:0] rb_val;

  always_comb begin
    is_long = (int'(bitcnt) == LONG_LEN);
    mode_s  = is_long ? mode_e'(shreg[LONG_LEN-1 -: MODE_W])
                      : mode_e'(shreg[SHORT_LEN-1 -: MODE_W]);
    addr_s  = is_long ? shreg[CODE_W +: ADDR_W] : shreg[ADDR_W-1:0];
    code_s  = shreg[CODE_W-1:0];
    mask_s  = addr_mask(addr_s);
    cmd_end = fr_end & ~in_rb;
    len_ok  = len_matches(mode_s, 32'(bitcnt));
    wr_try  = cmd_end & len_ok & (mode_s == M_WRITE) & (mask_s != '0);
    wr_bad  = wr_try & prev_dac & ~gap_ok_start;
    wr_go   = wr_try & ~wr_bad;
    acq_go  = cmd_end & len_ok & ((mode_s == M_ACQ) | (mode_s == M_ACQ_RB));
    arm_go  = cmd_end & len_ok & ((mode_s == M_RB) | (mode_s == M_ACQ_RB))
            & (mask_s != '0) & (addr_s != ADDR_ALL);
    rb_start = fr_start & rb_arm;
    rb_viol  = rb_start & (~gap_ok_now | (rb_acq & acq_busy[rb_idx]));
    rb_val   = rb_viol ? '0 : bank[rb_idx];
  end

  for (genvar g = 0; g <= NCH; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  bank[g] <= '0;
      else if (wr_go && mask_s[g]) bank[g] <= code_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_req  <= '0;
      dac_wr   <= '0;
      dac_code <= '0;
      err      <= 1'b0;
      prev_dac <= 1'b0;
      rb_arm   <= 1'b0;
      rb_acq   <= 1'b0;
      rb_idx   <= '0;
      in_rb    <= 1'b0;
    end else begin
      acq_req <= acq_go ? mask_s : '0;
      dac_wr  <= wr_go  ? mask_s : '0;
      if (wr_go) dac_code <= code_s;
      if (wr_bad || rb_viol) err <= 1'b1;
      if (cmd_end && len_ok) prev_dac <= (mode_s == M_WRITE);
      if (arm_go) begin
        rb_arm <= 1'b1;
        rb_acq <= (mode_s == M_ACQ_RB);
        rb_idx <= addr_idx(addr_s);
      end else if (rb_start) begin
        rb_arm <= 1'b0;
      end
      if (rb_start)    in_rb <= 1'b1;
      else if (fr_end) in_rb <= 1'b0;
    end
  end

  sdac_readback #(.CW(CODE_W)) u_rb (
    .clk(clk), .rst_n(rst_n), .load(rb_start), .load_val(rb_val),
    .shift(bit_evt & in_rb), .stop(fr_end), .dout(dout)
  );

  // R3
  acq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_req != '0) |=> (acq_req == '0));

  // R2
  wr_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_wr != '0) |-> $past(fr_end));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R5
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rb |-> !dout);

  // R9
  wr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_end && prev_dac && !gap_ok_start) |=> (dac_wr == '0));
endmodule

// File: tb/sdac_cmd_if_tb.sv
module sdac_cmd_if_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32;
  localparam int MIN_GAP = 40;
  localparam int ACQ_CYC = 200;
  localparam int GAP_OK = 60;
  localparam int GAP_BAD = 10;

  logic clk = 1'b0;
  logic rst_n, sync_n, sclk, sdin;
  logic [NCH:0] acq_busy, acq_req, dac_wr;
  logic [13:0] dac_code;
  logic dout, err;

  int checks = 0, errors = 0;
  logic [NCH:0] acq_seen, wr_seen;
  int acq_n;
  logic [13:0] wr_code;
  int busy_cnt [NCH+1];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdac_cmd_if #(.NCH(NCH), .MIN_GAP(MIN_GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
    .acq_busy(acq_busy), .dout(dout), .acq_req(acq_req), .dac_wr(dac_wr),
    .dac_code(dac_code), .err(err)
  );

  // sequencer model: busy for ACQ_CYC cycles after a request
  always @(posedge clk) begin
    for (int i = 0; i <= NCH; i++) begin
      if (!rst_n) busy_cnt[i] <= 0;
      else if (acq_req[i]) busy_cnt[i] <= ACQ_CYC;
      else if (busy_cnt[i] > 0) busy_cnt[i] <= busy_cnt[i] - 1;
    end
  end
  always_comb for (int i = 0; i <= NCH; i++) acq_busy[i] = (busy_cnt[i] > 0);

  always @(posedge clk) begin
    if (acq_req != '0) begin
      acq_seen <= acq_seen | acq_req;
      acq_n <= acq_n + 1;
    end
    if (dac_wr != '0) begin
      wr_seen <= wr_seen | dac_wr;
      wr_code <= dac_code;
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_seen();
    @(negedge clk);
    acq_seen = '0; wr_seen = '0; acq_n = 0; wr_code = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sync_n = 1'b1; sclk = 1'b1; sdin = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    clear_seen();
  endtask

  task automatic send(logic [23:0] w, int n, int gap_after);
    sync_n = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = w[i];
      wait_clk(2);
      sclk = 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(2);
    end
    wait_clk(2);
    sync_n = 1'b1;
    sdin = 1'b0;
    wait_clk(gap_after);
  endtask

  task automatic read14(output logic [13:0] v);
    sync_n = 1'b0;
    wait_clk(4);
    for (int i = 13; i >= 0; i--) begin
      wait_clk(2);
      v[i] = dout;
      sclk = 1'b0;
      wait_clk(4);
      sclk = 1'b1;
    end
    wait_clk(4);
    sync_n = 1'b1;
    wait_clk(GAP_OK);
  endtask

  function automatic logic [23:0] f_wr(logic [7:0] a, logic [13:0] c);
    return {2'b01, a, c};
  endfunction
  function automatic logic [23:0] f_sh(logic [1:0] m, logic [7:0] a);
    return {14'd0, m, a};
  endfunction

  task automatic rd_chan(logic [7:0] a, int gap, output logic [13:0] v);
    send(f_sh(2'b11, a), 10, gap);
    read14(v);
  endtask

  task automatic t_reset();
    logic [13:0] v;
    do_reset();
    chk("R1 dout", dout, 0);
    chk("R1 err", err, 0);
    chk("R1 acq_req", acq_req, 0);
    chk("R1 dac_wr", dac_wr, 0);
    rd_chan(8'd5, GAP_OK, v);
    chk("R1 reg ch5", v, 0);
    chk("R5 dout after read", dout, 0);
  endtask

  task automatic t_write();
    logic [13:0] v;
    do_reset();
    send(f_wr(8'd5, 14'h2A5C), 24, GAP_OK);
    chk("R2 strobe", wr_seen, 33'h1 << 5);
    chk("R2 code", wr_code, 14'h2A5C);
    rd_chan(8'd5, GAP_OK, v);
    chk("R5 readback ch5", v, 14'h2A5C);
    rd_chan(8'd6, GAP_OK, v);
    chk("R2 ch6 untouched", v, 0);
    chk("R2 err", err, 0);
  endtask

  task automatic t_broadcast();
    logic [13:0] v;
    do_reset();
    send(f_wr(8'd63, 14'h1234), 24, GAP_OK);
    chk("R4 all strobe", wr_seen, {(NCH+1){1'b1}});
    clear_seen();
    send(f_wr(8'd32, 14'h0F0F), 24, GAP_OK);
    chk("R4 ofs strobe", wr_seen, 33'h1 << 32);
    rd_chan(8'd31, GAP_OK, v);
    chk("R4 ch31", v, 14'h1234);
    rd_chan(8'd32, GAP_OK, v);
    chk("R4 ofs", v, 14'h0F0F);
  endtask

  task automatic t_acq();
    do_reset();
    send(f_sh(2'b00, 8'd7), 10, GAP_OK);
    chk("R3 ch7 req", acq_seen, 33'h1 << 7);
    chk("R3 one pulse", acq_n, 1);
    clear_seen();
    send(f_sh(2'b00, 8'd63), 10, GAP_OK);
    chk("R3 all req", acq_seen, {(NCH+1){1'b1}});
    clear_seen();
    send(f_sh(2'b00, 8'd32), 10, GAP_OK);
    chk("R3 ofs req", acq_seen, 33'h1 << 32);
    chk("R3 no write", wr_seen, 0);
  endtask

  task automatic t_acq_rb();
    logic [13:0] v;
    do_reset();
    send(f_wr(8'd3, 14'h3C3C), 24, GAP_OK);
    clear_seen();
    send(f_sh(2'b10, 8'd3), 10, ACQ_CYC + 100);
    chk("R6 acq req", acq_seen, 33'h1 << 3);
    read14(v);
    chk("R6 done read", v, 14'h3C3C);
    chk("R6 err clear", err, 0);
    send(f_sh(2'b10, 8'd3), 10, GAP_OK);
    read14(v);
    chk("R6 busy read zeros", v, 0);
    chk("R6 busy err", err, 1);
    send(f_wr(8'd4, 14'h0001), 24, GAP_OK);
    chk("R10 err held", err, 1);
    do_reset();
    chk("R10 err reset", err, 0);
  endtask

  task automatic t_length();
    do_reset();
    send({13'd0, 3'b000, 8'd4}, 11, GAP_OK);
    send(f_sh(2'b01, 8'd4), 10, GAP_OK);
    send(f_wr(8'd4, 14'h0155) >> 1, 23, GAP_OK);
    send({2'b00, 8'd4, 14'd0}, 24, GAP_OK);
    chk("R7 no acq", acq_seen, 0);
    chk("R7 no write", wr_seen, 0);
    chk("R7 no err", err, 0);
  endtask

  task automatic t_addr();
    do_reset();
    send(f_wr(8'd40, 14'h0123), 24, GAP_OK);
    send(f_sh(2'b00, 8'd100), 10, GAP_OK);
    chk("R8 no write", wr_seen, 0);
    chk("R8 no acq", acq_seen, 0);
    send(f_sh(2'b11, 8'd50), 10, GAP_OK);
    send(f_wr(8'd2, 14'h1111), 24, GAP_OK);
    chk("R8 read not armed", wr_seen, 33'h1 << 2);
    clear_seen();
    send(f_sh(2'b11, 8'd63), 10, GAP_OK);
    send(f_wr(8'd2, 14'h2222), 24, GAP_OK);
    chk("R8 all read not armed", wr_code, 14'h2222);
  endtask

  task automatic t_spacing();
    logic [13:0] v;
    do_reset();
    send(f_wr(8'd1, 14'h0AAA), 24, GAP_BAD);
    clear_seen();
    send(f_wr(8'd1, 14'h1555), 24, GAP_OK);
    chk("R9 write rejected", wr_seen, 0);
    chk("R9 write err", err, 1);
    rd_chan(8'd1, GAP_OK, v);
    chk("R9 old value kept", v, 14'h0AAA);
    do_reset();
    send(f_wr(8'd2, 14'h0777), 24, GAP_OK);
    rd_chan(8'd2, GAP_BAD, v);
    chk("R9 early read zeros", v, 0);
    chk("R9 read err", err, 1);
  endtask

  initial begin
    t_reset();
    t_write();
    t_broadcast();
    t_acq();
    t_acq_rb();
    t_length();
    t_addr();
    t_spacing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule